// File: doc/BRIEF.md
# Quasi-Cyclic LDPC Systematic Encoder

This block turns a block of systematic bits into a full codeword of a quasi-cyclic LDPC code. The parity-check matrix is a J by L grid of q by q tiles. Each tile is either empty or the identity with its rows rotated right by a per-tile shift. The parity half of the matrix is lower triangular across its first J−2 block-rows. The last two block-rows are folded together into one dual-diagonal staircase. Tile shifts and the empty/occupied map are constant parameters, and q must be a power of two.

The host shifts (L−J)·q systematic bits in through a serial load port, then pulses start. The encoder works through the parity bits in order, one at a time. For each bit it walks the block-columns one per cycle and XORs in the bit found at the circulant-rotated address of every occupied tile. The first J−2 parity parts each come straight from these sums. The last 2q sums feed a running XOR chain: even chain steps use block-row J−1 and odd steps use block-row J. The first q chain outputs form parity part J−1, and the chain then carries on without a reset to form part J. When the last bit is stored, a one-cycle done pulse is raised. The whole codeword can then be read at random from a bit-addressed read port.

Top module: `qcLdpcEncoder`

## Requirements
- R1: After reset, done is low and every codeword position reads 0.
- R2: Each cycle with loadValid high while idle stores loadBit at the next systematic position. Positions start at 0 and wrap to 0 after (L−J)·q bits.
- R3: The systematic positions keep their loaded values through encoding. Load strobes that arrive while encoding are ignored.
- R4: For block-row r with r < J−2 (0-based), parity bit i is the XOR over occupied tiles k of the bit at k·q + ((i + shift[r][k]) mod q). The result is stored at (L−J+r)·q + i.
- R5: Chain step t (t = 0 … 2q−1) forms a sum over block-row J−2 for even t and over block-row J−1 for odd t, at row position t/2. It XORs that sum with the previous chain output (0 before step 0) and stores it at (L−2)·q + t. Steps t < q form parity part J−1.
- R6: The second parity part of the chain (steps q … 2q−1) continues from the final bit of the first part rather than from zero.
- R7: An empty tile contributes nothing. A tile in a parity block-column at or right of the row's own diagonal contributes nothing.
- R8: done is high for exactly one cycle. It rises J·q·(L−1) clock edges after the edge that accepted start.
- R9: A start pulse during encoding does not restart the run and does not produce an extra done.
- R10: A start presented in the cycle that done is high is accepted and begins a new run. The new run repeats the same codeword from the same systematic bits.
- R11: rdBit shows, without a clock delay, the codeword bit at rdAddr, where rdAddr = blockColumn·q + position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Serial load strobe |
| loadBit | input | 1 | Serial systematic data bit |
| start | input | 1 | Begin encoding (pulse) |
| rdAddr | input | log2(q·L) | Codeword read address |
| rdBit | output | 1 | Codeword bit at rdAddr |
| done | output | 1 | One-cycle end-of-encode pulse |

## Verification
The completion of one run and the acceptance of the next start can fall in the same cycle. That cycle is the one in which done is high and the controller has just gone idle. The bench provokes this by raising start as soon as it sees done. A cycle-level reference of the run/idle state predicts done on every clock, so a lost start or a stretched pulse shows as a mismatch. The second run's codeword must match the first bit for bit. Start and load strobes sent in mid-run are judged the same way: done must stay on its predicted cycle, and the codeword must still follow the originally loaded bits.

// File: rtl/qcLdpcPkg.sv
package qcLdpcPkg;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_RUN  = 1'b1
  } qcState_e;

  typedef struct packed {
    logic idle;      // controller waiting for start
    logic accEn;     // fold one tile term into the accumulator
    logic wrEn;      // store the finished parity bit
    logic runClr;    // start accepted: clear accumulator and chain
  } qcStrobe_t;

endpackage

// File: rtl/qcLdpcCtrl.sv
module qcLdpcCtrl
  import qcLdpcPkg::*;
#(
  parameter int Q = 8,
  parameter int J = 4,
  parameter int L = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  output qcStrobe_t                 strb,
  output logic [$clog2(L)-1:0]      termIdx,
  output logic [$clog2(J*Q)-1:0]    bitIdx,
  output logic                      done
);

  localparam int TW        = $clog2(L);
  localparam int BW        = $clog2(J*Q);
  localparam int LAST_TERM = L - 2;     // step that writes instead of reading
  localparam int LAST_BIT  = J*Q - 1;

  qcState_e state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      termIdx <= '0;
      bitIdx  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state   <= S_RUN;
            termIdx <= '0;
            bitIdx  <= '0;
          end
        end
        S_RUN: begin
          if (termIdx == TW'(LAST_TERM)) begin
            termIdx <= '0;
            if (bitIdx == BW'(LAST_BIT)) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            termIdx <= termIdx + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.idle   = (state == S_IDLE);
    strb.accEn  = (state == S_RUN) && (termIdx != TW'(LAST_TERM));
    strb.wrEn   = (state == S_RUN) && (termIdx == TW'(LAST_TERM));
    strb.runClr = (state == S_IDLE) && start;
  end

endmodule

// File: rtl/qcLdpcPath.sv
module qcLdpcPath
  import qcLdpcPkg::*;
#(
  parameter int Q = 8,
  parameter int J = 4,
  parameter int L = 8,
  parameter int SHIFT [0:J-1][0:L-1] = '{
    '{1, 3, 5, 0, 0, 0, 0, 0},
    '{2, 0, 6, 7, 4, 0, 0, 0},
    '{0, 5, 1, 3, 2, 6, 0, 0},
    '{7, 4, 0, 2, 0, 3, 0, 0}
  },
  parameter bit [L-1:0] MASK [0:J-1] = '{8'h0F, 8'h1D, 8'h3E, 8'h2B}
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  qcStrobe_t                 strb,
  input  logic [$clog2(L)-1:0]      termIdx,
  input  logic [$clog2(J*Q)-1:0]    bitIdx,
  input  logic                      loadValid,
  input  logic                      loadBit,
  output logic [Q*L-1:0]            mem
);

  localparam int N        = Q * L;
  localparam int K        = (L - J) * Q;
  localparam int AW       = $clog2(N);
  localparam int QW       = $clog2(Q);
  localparam int KW       = $clog2(K);
  localparam int RW       = $clog2(J);
  localparam int BW       = $clog2(J*Q);
  localparam int TRI_BITS = (J - 2) * Q;

  // Tiles that may contribute: occupied and left of the row's own diagonal.
  logic [L-1:0] rowLive [0:J-1];

  for (genvar r = 0; r < J; r++) begin : g_row
    for (genvar k = 0; k < L; k++) begin : g_col
      if (k < L - J + r) begin : g_on
        assign rowLive[r][k] = MASK[r][k];
      end else begin : g_off
        assign rowLive[r][k] = 1'b0;
      end
    end
  end

  logic            inChain;
  logic [QW:0]     chainT;
  logic [RW-1:0]   rowSel;
  logic [QW-1:0]   posSel;
  logic [QW-1:0]   colSel;
  logic [AW-1:0]   termAddr;
  logic [AW-1:0]   wrAddr;
  logic            termBit;
  logic            wrBit;
  logic            acc;
  logic            chain;
  logic [KW-1:0]   loadPtr;

  always_comb begin
    inChain = (bitIdx >= BW'(TRI_BITS));
    chainT  = (QW+1)'(bitIdx - BW'(TRI_BITS));
    if (inChain) begin
      rowSel = RW'(J - 2) + RW'(chainT[0]);
      posSel = chainT[QW:1];
    end else begin
      rowSel = RW'(bitIdx >> QW);
      posSel = bitIdx[QW-1:0];
    end
    // modulo-q rotation falls out of the QW-bit truncation
    colSel   = posSel + QW'(SHIFT[rowSel][termIdx]);
    termAddr = {termIdx, colSel};
    termBit  = rowLive[rowSel][termIdx] & mem[termAddr];
    wrAddr   = AW'(K) + AW'(bitIdx);
    wrBit    = acc ^ (inChain & chain);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mem     <= '0;
      acc     <= 1'b0;
      chain   <= 1'b0;
      loadPtr <= '0;
    end else begin
      if (strb.runClr) begin
        acc   <= 1'b0;
        chain <= 1'b0;
      end
      if (strb.idle && loadValid) begin
        mem[AW'(loadPtr)] <= loadBit;
        loadPtr <= (loadPtr == KW'(K - 1)) ? '0 : loadPtr + 1'b1;
      end
      if (strb.accEn) begin
        acc <= acc ^ termBit;
      end
      if (strb.wrEn) begin
        mem[wrAddr] <= wrBit;
        acc         <= 1'b0;
        if (inChain) begin
          chain <= wrBit;
        end
      end
    end
  end

endmodule

// File: rtl/qcLdpcEncoder.sv
module qcLdpcEncoder
  import qcLdpcPkg::*;
#(
  parameter int Q = 8,
  parameter int J = 4,
  parameter int L = 8,
  parameter int SHIFT [0:J-1][0:L-1] = '{
    '{1, 3, 5, 0, 0, 0, 0, 0},
    '{2, 0, 6, 7, 4, 0, 0, 0},
    '{0, 5, 1, 3, 2, 6, 0, 0},
    '{7, 4, 0, 2, 0, 3, 0, 0}
  },
  parameter bit [L-1:0] MASK [0:J-1] = '{8'h0F, 8'h1D, 8'h3E, 8'h2B}
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      loadValid,
  input  logic                      loadBit,
  input  logic                      start,
  input  logic [$clog2(Q*L)-1:0]    rdAddr,
  output logic                      rdBit,
  output logic                      done
);

  qcStrobe_t                  strb;
  logic [$clog2(L)-1:0]       termIdx;
  logic [$clog2(J*Q)-1:0]     bitIdx;
  logic [Q*L-1:0]             mem;
  logic                       busy;

  qcLdpcCtrl #(.Q(Q), .J(J), .L(L)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strb    (strb),
    .termIdx (termIdx),
    .bitIdx  (bitIdx),
    .done    (done)
  );

  qcLdpcPath #(.Q(Q), .J(J), .L(L), .SHIFT(SHIFT), .MASK(MASK)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .termIdx   (termIdx),
    .bitIdx    (bitIdx),
    .loadValid (loadValid),
    .loadBit   (loadBit),
    .mem       (mem)
  );

  assign busy  = ~strb.idle;
  assign rdBit = mem[rdAddr];

endmodule

// File: rtl/qcLdpcChecker.sv
module qcLdpcChecker #(
  parameter int Q = 8,
  parameter int J = 4,
  parameter int L = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [Q*L-1:0]  mem
);

  localparam int K   = (L - J) * Q;
  localparam int LAT = J * Q * (L - 1);

  int runCnt;

  always_ff @(posedge clk) begin
    if (!rstN)              runCnt <= 0;
    else if (!busy && start) runCnt <= 0;
    else if (busy)           runCnt <= runCnt + 1;
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runCnt == LAT));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R3
  sys_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(mem[K-1:0]));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && (runCnt < LAT - 1)) |=> busy);

endmodule

bind qcLdpcEncoder qcLdpcChecker #(.Q(Q), .J(J), .L(L)) u_qcLdpcChecker (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done),
  .mem   (mem)
);

// File: tb/qcLdpcEncoder_bench.sv
module qcLdpcEncoder_bench;

  localparam int Q   = 8;
  localparam int J   = 4;
  localparam int L   = 8;
  localparam int N   = Q * L;
  localparam int K   = (L - J) * Q;
  localparam int AW  = $clog2(N);
  localparam int LAT = J * Q * (L - 1);

  localparam int SH [0:J-1][0:L-1] = '{
    '{1, 3, 5, 0, 0, 0, 0, 0},
    '{2, 0, 6, 7, 4, 0, 0, 0},
    '{0, 5, 1, 3, 2, 6, 0, 0},
    '{7, 4, 0, 2, 0, 3, 0, 0}
  };
  localparam bit [L-1:0] MK [0:J-1] = '{8'h0F, 8'h1D, 8'h3E, 8'h2B};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadValid = 1'b0;
  logic          loadBit = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic          rdBit;
  logic          done;

  always #2 clk = ~clk;

  qcLdpcEncoder #(.Q(Q), .J(J), .L(L), .SHIFT(SH), .MASK(MK)) u_qcLdpcEncoder (
    .clk (clk), .rstN (rstN), .loadValid (loadValid), .loadBit (loadBit),
    .start (start), .rdAddr (rdAddr), .rdBit (rdBit), .done (done)
  );

  int checks = 0;
  int errors = 0;
  bit uVec  [K];
  bit refCw [N];
  bit gotCw [N];
  bit refBusy = 1'b0;
  bit refDone = 1'b0;
  int refCnt = 0;

  // cycle reference of the run/idle state (R8 R9 R10)
  always @(posedge clk) begin
    if (!rstN) begin
      refBusy = 1'b0; refDone = 1'b0; refCnt = 0;
    end else begin
      refDone = 1'b0;
      if (!refBusy) begin
        if (start) begin refBusy = 1'b1; refCnt = 0; end
      end else begin
        refCnt++;
        if (refCnt == LAT) begin refBusy = 1'b0; refDone = 1'b1; end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (done !== refDone) begin
        errors++;
        $display("FAIL R8 done per-clock actual %0b expected %0b", done, refDone);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit rowSum(input int r, input int i);
    bit s = 1'b0;
    for (int k = 0; k < L; k++)
      if (k < L - J + r && MK[r][k]) s ^= refCw[k*Q + (i + SH[r][k]) % Q];
    return s;
  endfunction

  function automatic bit gotSum(input int r, input int i);
    bit s = 1'b0;
    for (int k = 0; k < L; k++)
      if (k < L - J + r && MK[r][k]) s ^= gotCw[k*Q + (i + SH[r][k]) % Q];
    return s;
  endfunction

  task automatic computeRef();
    bit w = 1'b0;
    for (int a = 0; a < N; a++) refCw[a] = (a < K) ? uVec[a] : 1'b0;
    for (int r = 0; r < J - 2; r++)
      for (int i = 0; i < Q; i++) refCw[(L-J+r)*Q + i] = rowSum(r, i);
    for (int t = 0; t < 2*Q; t++) begin
      w ^= rowSum(J - 2 + (t % 2), t / 2);
      refCw[(L-2)*Q + t] = w;
    end
  endtask

  task automatic loadBits(input int cnt, input int offset);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      loadValid = 1'b1;
      loadBit   = uVec[(i + offset) % K];
    end
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic waitDone();
    int g = 0;
    while (!done && g < LAT + 20) begin
      @(negedge clk);
      g++;
    end
    check(done, "R8 done seen", int'(done), 1);
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic readAll();
    for (int a = 0; a < N; a++) begin
      @(negedge clk);
      rdAddr = AW'(a);
      #1;
      gotCw[a] = rdBit;
    end
  endtask

  task automatic compareCw(input string name);
    for (int a = 0; a < N; a++) begin
      string tag;
      if (a < K)                 tag = "R3 systematic";
      else if (a < (L-2)*Q)      tag = "R4 R7 triangular";
      else if (a < (L-1)*Q)      tag = "R5 chain first part";
      else                       tag = "R6 chain second part";
      check(gotCw[a] == refCw[a], $sformatf("%s %s bit %0d", tag, name, a),
            int'(gotCw[a]), int'(refCw[a]));
    end
  endtask

  task automatic syndromeCheck(input string name);
    int bad = 0;
    bit prev = 1'b0;
    for (int r = 0; r < J - 2; r++)
      for (int i = 0; i < Q; i++)
        if (gotSum(r, i) ^ gotCw[(L-J+r)*Q + i]) bad++;
    for (int t = 0; t < 2*Q; t++) begin
      bit cur = gotCw[(L-2)*Q + t];
      if (gotSum(J - 2 + (t % 2), t / 2) ^ cur ^ prev) bad++;
      prev = cur;
    end
    check(bad == 0, $sformatf("R4 R5 R6 parity checks %s", name), bad, 0);
  endtask

  task automatic runCase(input string name);
    computeRef();
    loadBits(K, 0);
    pulseStart();
    waitDone();
    readAll();
    compareCw(name);
    syndromeCheck(name);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    readAll();
    for (int a = 0; a < N; a++)
      check(gotCw[a] == 1'b0, $sformatf("R1 R11 reset read addr %0d", a), int'(gotCw[a]), 0);

    // all-zero input
    for (int i = 0; i < K; i++) uVec[i] = 1'b0;
    runCase("zero");

    // single ones at first, last and an interior position (R7 via masked tiles)
    for (int i = 0; i < K; i++) uVec[i] = 1'b0;
    uVec[0] = 1'b1;      runCase("one@0");
    uVec[0] = 1'b0; uVec[K-1] = 1'b1; runCase("one@last");
    uVec[K-1] = 1'b0; uVec[11] = 1'b1; runCase("one@11");
    uVec[11] = 1'b0;

    // random inputs
    for (int n = 0; n < 3; n++) begin
      for (int i = 0; i < K; i++) uVec[i] = 1'($urandom());
      runCase($sformatf("rand%0d", n));
    end

    // R2 wrap: junk in the first three, then wrap over them
    for (int i = 0; i < K; i++) uVec[i] = 1'($urandom());
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); loadValid = 1'b1; loadBit = ~uVec[i];
    end
    loadBits(K, 3);          // ends with uVec[0..2] over the junk
    loadBits(K - 3, 3);      // realign pointer to 0, same contents
    readAll();
    for (int a = 0; a < K; a++)
      check(gotCw[a] == uVec[a], $sformatf("R2 R11 load wrap addr %0d", a),
            int'(gotCw[a]), int'(uVec[a]));
    computeRef();
    pulseStart();
    waitDone();
    readAll();
    compareCw("wrap");

    // R9: start and load strobes during a run
    for (int i = 0; i < K; i++) uVec[i] = 1'($urandom());
    computeRef();
    loadBits(K, 0);
    pulseStart();
    repeat (20) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      start = 1'b1; loadValid = 1'b1; loadBit = 1'($urandom());
    end
    @(negedge clk);
    start = 1'b0; loadValid = 1'b0;
    waitDone();
    check(refCnt == LAT, "R9 single run length", refCnt, LAT);
    readAll();
    compareCw("R9 busy strobes");

    // R10: start in the done cycle
    pulseStart();
    waitDone();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(refBusy == 1'b1, "R10 restart accepted", int'(refBusy), 1);
    waitDone();
    readAll();
    compareCw("R10 back-to-back");
    syndromeCheck("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule